// File: doc/BRIEF.md
# Sixteen-Source Interrupt Handler

This block collects sixteen interrupt request lines and presents them to a processor as two outputs: a fast request and a normal request. Each source has its own configuration word. The word picks edge or level sensing, a five-bit priority, and which of the two outputs the source drives. A source that is pending and not masked competes with the other sources routed to the same output. The winner's number is latched in a readable register, and the output stays asserted until software acknowledges it.

Software uses a plain 16-bit register bus with single-cycle writes and combinational reads. It can clear pending bits, mask sources and raise software interrupts. Software interrupts are honoured only for sources configured as edge sensitive. Each output has a self-clearing acknowledge bit that releases the output lock. Software should clear the winner's pending bit before acknowledging, or the same source wins again straight away.

Register word offsets:

| Offset | Register |
|---|---|
| 0x00 | pending |
| 0x02 | mask |
| 0x04 | fast winner |
| 0x06 | normal winner |
| 0x08 | acknowledge |
| 0x0A | software set |
| 0x0C + 2n | configuration word of source n |

Top module: `irq_hub`

## Requirements
- R1: After reset both outputs are low, the mask register (offset 0x00 is pending, 0x02 is mask) reads 0xFFFF, the pending register reads 0, and every configuration word reads 0.
- R2: For an edge-sensitive source (configuration bit 1 = 0), a rising input edge sets its pending bit in the same clock edge that samples the rise. The bit stays set after the input falls and clears only when software writes 1 to that bit at offset 0x00.
- R3: For a level-sensitive source (configuration bit 1 = 1), the pending bit equals the input value sampled on the previous clock edge.
- R4: Writing 1s to the software-set register at offset 0x0A sets the pending bits of edge-sensitive sources only. Level-sensitive sources are unaffected, and the register reads as 0.
- R5: A source whose mask bit (offset 0x02) is 1 never asserts an output, even while it is pending.
- R6: Configuration bit 0 routes a source to the fast output (1) or the normal output (0). Bits 6:2 hold its priority.
- R7: Among the unmasked pending sources routed to one output, the lowest priority value wins, and ties go to the lowest source number. The winner number reads in bits 3:0 of offset 0x04 (fast) or 0x06 (normal).
- R8: While an output is asserted and not acknowledged, it stays high and its winner number stays unchanged, even when a better source becomes pending.
- R9: Writing 1 to bit 1 (fast) or bit 0 (normal) of offset 0x08 drops that output and clears its winner number to 0 on that clock edge. A new arbitration may assert the output on the next edge. Offset 0x08 reads as 0.
- R10: An output that is idle asserts on the clock edge after an eligible source's pending bit is set.
- R11: The configuration word of source n sits at offset 0x0C + 2n and holds 7 bits. Its upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Interrupt source lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write (1) or read (0) |
| bus_addr | input | 6 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
A corrupted pending bit shows within one clock, either as an unexpected output assertion or as a wrong value when the pending register is read back. A faulty arbiter shows as a wrong winner number read back on the cycle after the output rises. A broken lock or acknowledge path shows as an output that drops without an acknowledge, or that stays high through one. It can also show as a winner number that changes while the output is held high, and each of these appears within one or two clocks of the triggering write or input edge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [2:0] {
    RS_NONE, RS_PEND, RS_MASK, RS_FNUM, RS_INUM, RS_ACK, RS_SOFT, RS_CFG
  } reg_sel_e;

  localparam int CFG_ROUTE_BIT = 0;
  localparam int CFG_SENSE_BIT = 1;
  localparam int CFG_PRIO_LSB  = 2;

  localparam int OFS_PEND = 'h00;
  localparam int OFS_MASK = 'h02;
  localparam int OFS_FNUM = 'h04;
  localparam int OFS_INUM = 'h06;
  localparam int OFS_ACK  = 'h08;
  localparam int OFS_SOFT = 'h0A;
  localparam int OFS_CFG  = 'h0C;

  localparam int ACK_FAST_BIT = 1;
  localparam int ACK_NORM_BIT = 0;
endpackage

// File: rtl/irq_hub_pend.sv
module irq_hub_pend #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] lvl_mode_i,
  input  logic [N_SRC-1:0] soft_set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] rise;

  assign rise = src_i & ~prev_q;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      if (lvl_mode_i[i]) pend_d[i] = src_i[i];
      else               pend_d[i] = (pend_q[i] & ~clr_i[i]) | rise[i] | soft_set_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= src_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_mode_i[g] |=> (pend_o[g] == $past(src_i[g])));
    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode_i[g] && pend_o[g] && !clr_i[g]) |=> pend_o[g]);
  end
endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int N_SRC  = 16,
  parameter int PRIO_W = 5,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             cand_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         any_o,
  output logic [SRC_W-1:0]             win_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (!any_o || prio_i[i] <= best)) begin
        any_o = 1'b1;
        best  = prio_i[i];
        win_o = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub_out.sv
module irq_hub_out #(
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [SRC_W-1:0] win_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [SRC_W-1:0] num_o
);
  logic             req_q, req_d;
  logic [SRC_W-1:0] num_q, num_d;
  logic             upd_en;

  always_comb begin
    req_d = req_q;
    num_d = num_q;
    if (ack_i) begin
      req_d = 1'b0;
      num_d = '0;
    end else if (!req_q && any_i) begin
      req_d = 1'b1;
      num_d = win_i;
    end
  end

  assign upd_en = ack_i | (!req_q & any_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      num_q <= '0;
    end else if (upd_en) begin
      req_q <= req_d;
      num_q <= num_d;
    end
  end

  assign req_o = req_q;
  assign num_o = num_q;

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(num_o)));
  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (!req_o && num_o == '0));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int PRIO_W = 5,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int SRC_W = $clog2(N_SRC);
  localparam int CFG_W = CFG_PRIO_LSB + PRIO_W;
  localparam int CFG_LAST = OFS_CFG + 2 * (N_SRC - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // address decode
  reg_sel_e         rsel;
  logic [SRC_W-1:0] cfg_idx;
  logic             wr_en;

  assign cfg_idx = SRC_W'(bus_addr[ADDR_W-1:1] - (ADDR_W-1)'(OFS_CFG / 2));
  assign wr_en   = bus_sel & bus_wr;

  always_comb begin
    rsel = RS_NONE;
    if (bus_sel) begin
      if      (bus_addr == ADDR_W'(OFS_PEND)) rsel = RS_PEND;
      else if (bus_addr == ADDR_W'(OFS_MASK)) rsel = RS_MASK;
      else if (bus_addr == ADDR_W'(OFS_FNUM)) rsel = RS_FNUM;
      else if (bus_addr == ADDR_W'(OFS_INUM)) rsel = RS_INUM;
      else if (bus_addr == ADDR_W'(OFS_ACK))  rsel = RS_ACK;
      else if (bus_addr == ADDR_W'(OFS_SOFT)) rsel = RS_SOFT;
      else if (!bus_addr[0] && bus_addr >= ADDR_W'(OFS_CFG) &&
               bus_addr <= ADDR_W'(CFG_LAST)) rsel = RS_CFG;
    end
  end

  // mask register
  logic [N_SRC-1:0] mask_q;
  logic             mask_we;
  assign mask_we = wr_en & (rsel == RS_MASK);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '1;
    else if (mask_we) mask_q <= bus_wdata[N_SRC-1:0];
  end

  // per-source configuration words
  logic [N_SRC-1:0][CFG_W-1:0]  cfg_q;
  logic [N_SRC-1:0]             lvl_mode, to_fast;
  logic [N_SRC-1:0][PRIO_W-1:0] prio;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cfg
    logic cfg_we;
    assign cfg_we = wr_en & (rsel == RS_CFG) & (cfg_idx == SRC_W'(g));
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) cfg_q[g] <= '0;
      else if (cfg_we) cfg_q[g] <= bus_wdata[CFG_W-1:0];
    end
    assign to_fast[g]  = cfg_q[g][CFG_ROUTE_BIT];
    assign lvl_mode[g] = cfg_q[g][CFG_SENSE_BIT];
    assign prio[g]     = cfg_q[g][CFG_W-1:CFG_PRIO_LSB];
  end

  // pending state
  logic [N_SRC-1:0] pend, soft_set, pend_clr;
  assign soft_set = (wr_en && rsel == RS_SOFT) ? (bus_wdata[N_SRC-1:0] & ~lvl_mode) : '0;
  assign pend_clr = (wr_en && rsel == RS_PEND) ? bus_wdata[N_SRC-1:0] : '0;

  irq_hub_pend #(.N_SRC(N_SRC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .src_i      (src_i),
    .lvl_mode_i (lvl_mode),
    .soft_set_i (soft_set),
    .clr_i      (pend_clr),
    .pend_o     (pend)
  );

  // arbitration and output lock, fast and normal paths
  logic [N_SRC-1:0] cand_f, cand_n;
  logic             any_f, any_n, ack_f, ack_n;
  logic [SRC_W-1:0] win_f, win_n, num_f, num_n;

  assign cand_f = pend & ~mask_q & to_fast;
  assign cand_n = pend & ~mask_q & ~to_fast;
  assign ack_f  = wr_en & (rsel == RS_ACK) & bus_wdata[ACK_FAST_BIT];
  assign ack_n  = wr_en & (rsel == RS_ACK) & bus_wdata[ACK_NORM_BIT];

  irq_hub_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb_f (
    .cand_i (cand_f), .prio_i (prio), .any_o (any_f), .win_o (win_f));
  irq_hub_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb_n (
    .cand_i (cand_n), .prio_i (prio), .any_o (any_n), .win_o (win_n));

  irq_hub_out #(.SRC_W(SRC_W)) u_out_f (
    .clk (clk), .rst_n (rst_sync_n), .any_i (any_f), .win_i (win_f),
    .ack_i (ack_f), .req_o (fiq_o), .num_o (num_f));
  irq_hub_out #(.SRC_W(SRC_W)) u_out_n (
    .clk (clk), .rst_n (rst_sync_n), .any_i (any_n), .win_i (win_n),
    .ack_i (ack_n), .req_o (irq_o), .num_o (num_n));

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      case (rsel)
        RS_PEND: bus_rdata = DATA_W'(pend);
        RS_MASK: bus_rdata = DATA_W'(mask_q);
        RS_FNUM: bus_rdata = DATA_W'(num_f);
        RS_INUM: bus_rdata = DATA_W'(num_n);
        RS_CFG:  bus_rdata = DATA_W'(cfg_q[cfg_idx]);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cand_f == '0 && !fiq_o) |=> !fiq_o);
  // R10
  fast_raise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fiq_o && !ack_f && cand_f != '0) |=> fiq_o);
  // R10
  norm_raise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_o && !ack_n && cand_n != '0) |=> irq_o);
  // R7
  win_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_f |-> cand_f[win_f]);
endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_i;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        fiq_o, irq_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  irq_hub i_irq_hub (
    .clk (clk), .rst_n (rst_n), .src_i (src_i), .bus_sel (bus_sel),
    .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .fiq_o (fiq_o), .irq_o (irq_o));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    rd(6'h02, rv); chk("R1 mask", rv, 16'hFFFF);
    rd(6'h00, rv); chk("R1 pend", rv, 16'h0000);
    rd(6'h0C, rv); chk("R1 cfg0", rv, 16'h0000);
    chk("R1 fiq", {15'b0, fiq_o}, 16'h0);
    chk("R1 irq", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_cfg();
    wr(6'h2A, 16'hFFFF);
    rd(6'h2A, rv); chk("R11 cfg15 width", rv, 16'h007F);
    wr(6'h2A, 16'h0000);
    wr(6'h0E, 16'h0025);
    rd(6'h0E, rv); chk("R11 cfg1 offset", rv, 16'h0025);
  endtask

  task automatic t_edge();
    wr(6'h12, 16'h0010);            // src3 edge, normal, prio 4
    src_i[3] = 1'b1;
    @(negedge clk);
    rd(6'h00, rv); chk("R2 edge set", rv, 16'h0008);
    src_i[3] = 1'b0;
    repeat (2) @(negedge clk);
    rd(6'h00, rv); chk("R2 edge hold", rv, 16'h0008);
    chk("R5 masked idle", {14'b0, fiq_o, irq_o}, 16'h0);
    wr(6'h00, 16'h0008);
    rd(6'h00, rv); chk("R2 clear", rv, 16'h0000);
  endtask

  task automatic t_level();
    wr(6'h16, 16'h0002);            // src5 level
    src_i[5] = 1'b1;
    @(negedge clk);
    rd(6'h00, rv); chk("R3 level high", rv, 16'h0020);
    src_i[5] = 1'b0;
    @(negedge clk);
    rd(6'h00, rv); chk("R3 level low", rv, 16'h0000);
  endtask

  task automatic t_soft();
    wr(6'h18, 16'h0000);            // src6 edge
    wr(6'h1A, 16'h0002);            // src7 level
    wr(6'h0A, 16'h00C0);
    rd(6'h00, rv); chk("R4 soft edge only", rv, 16'h0040);
    rd(6'h0A, rv); chk("R4 soft reads 0", rv, 16'h0000);
    wr(6'h00, 16'h0040);
  endtask

  task automatic t_route_prio();
    wr(6'h10, 16'h000D);            // src2 fast prio 3
    wr(6'h14, 16'h000D);            // src4 fast prio 3
    wr(6'h1C, 16'h0000);            // src8 normal prio 0
    wr(6'h02, 16'hFEE9);            // unmask 1,2,4,8
    wr(6'h0A, 16'h0116);
    chk("R10 not yet", {14'b0, fiq_o, irq_o}, 16'h0);
    @(negedge clk);
    chk("R10 both raised", {14'b0, fiq_o, irq_o}, 16'h3);
    rd(6'h04, rv); chk("R7 tie lower index", rv, 16'h0002);
    rd(6'h06, rv); chk("R6 normal route", rv, 16'h0008);
  endtask

  task automatic t_lock();
    wr(6'h0C, 16'h0001);            // src0 fast prio 0
    wr(6'h02, 16'hFEE8);
    wr(6'h0A, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R8 held", {15'b0, fiq_o}, 16'h1);
    rd(6'h04, rv); chk("R8 number frozen", rv, 16'h0002);
  endtask

  task automatic t_ack();
    wr(6'h00, 16'h0004);
    wr(6'h08, 16'h0002);
    chk("R9 fast dropped", {15'b0, fiq_o}, 16'h0);
    rd(6'h04, rv); chk("R9 number cleared", rv, 16'h0000);
    chk("R9 normal untouched", {15'b0, irq_o}, 16'h1);
    rd(6'h08, rv); chk("R9 ack reads 0", rv, 16'h0000);
    @(negedge clk);
    chk("R9 rearm", {15'b0, fiq_o}, 16'h1);
    wr(6'h00, 16'h0001);
    wr(6'h08, 16'h0002);
    @(negedge clk);
    rd(6'h04, rv); chk("R7 next best prio", rv, 16'h0004);
    wr(6'h00, 16'h0100);
    wr(6'h08, 16'h0001);
    chk("R9 normal dropped", {15'b0, irq_o}, 16'h0);
    repeat (2) @(negedge clk);
    chk("R9 normal stays low", {15'b0, irq_o}, 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; src_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg();
    t_edge();
    t_level();
    t_soft();
    t_route_prio();
    t_lock();
    t_ack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule